// File: doc/BRIEF.md
# Multi-standard video sync timing generator

This block derives every horizontal and vertical timing signal a video camera needs from a single pixel-rate clock. A horizontal counter walks the clocks of one scan line, and a vertical counter steps once per half line. All outputs are decoded from these two counts plus a small colour-frame counter: horizontal drive, a line-rate square wave, a double-line-rate square wave, composite sync with equalising and broad pulses, composite blanking, vertical drive, an odd/even field flag, a first-field flag for the colour sequence, a line-alternate flag and a burst flag. Every output is active low.

A two-bit standard code picks the line length, the frame length and the vertical-interval layout. Code 00 selects the 525-line, 910-clock standard with a four-field colour sequence (NTSC). Code 10 selects the same raster with an eight-field sequence and line alternation (PAL-M). Code 11 selects the 625-line, 908-clock standard with an eight-field sequence and line alternation (PAL). Code 01 selects the 625-line, 908-clock standard with a four-field sequence and no line alternation (SECAM). Because a frame holds an odd number of lines and the vertical counter runs in half lines, the second field starts in the middle of a line, which gives interlace.

An external genlock block can re-phase the raster through two synchronous load ports. One port sets the horizontal count and the other sets the half-line count, and each takes priority over normal counting.

Top module: `sync_timing_gen`

## Requirements
- R1: A line lasts 910 clocks when std_i[0] is 0 (codes 00 and 10) and 908 clocks when std_i[0] is 1 (codes 01 and 11). The horizontal count wraps to 0 after the last clock of the line.
- R2: The half-line counter counts from 0 to 1049 for the 525-line codes and from 0 to 1249 for the 625-line codes, stepping at clocks 0 and half-line of every line. The second field starts at half-line count 525 or 625. fld_n_o is low throughout the second field.
- R3: A high hload_i loads hload_val_i into the horizontal count on the next edge, and a high vload_i loads vload_val_i into the half-line count, in place of counting.
- R4: hd_n_o is low for horizontal counts 0 to 95. fh_n_o is low for the first half line (counts below 455 or 454). f2h_n_o is low for the first 227 clocks of each half line.
- R5: Outside the vertical interval, sync_n_o is low only for horizontal counts 0 to 67.
- R6: The vertical interval covers the first 3n half lines of each field, with n = 6 for 525 lines and n = 5 for 625 lines. In its first n and last n half lines, sync_n_o is low for the first 34 clocks of each half line. In the middle n half lines, sync_n_o is low for the whole half line except its last 68 clocks.
- R7: blk_n_o is low for horizontal counts 0 to 153 on every line, and for the whole of the first 40 (525-line) or 50 (625-line) half lines of each field.
- R8: vd_n_o is low for the first 18 half lines of each field in the 525-line codes and the first 15 half lines in the 625-line codes.
- R9: A two-bit frame counter advances when the half-line count wraps. fld1_n_o is low during the first field only when the frame counter is 0 (codes 10 and 11, eight fields) or even (codes 00 and 01, four fields).
- R10: In codes 10 and 11, lalt_n_o inverts at the end of every line. In codes 00 and 01 it stays high.
- R11: bf_n_o is low for horizontal counts 76 to 107, but only outside the vertical blanking rows of R7.
- R12: While rst_n is low, all counters are zero. This gives low sync, drive, blanking, vertical drive and first-field outputs, with fld_n_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_i | input | 2 | Standard code (00, 01, 10, 11 as in R1) |
| hload_i | input | 1 | Load horizontal count |
| hload_val_i | input | 10 | Horizontal count to load |
| vload_i | input | 1 | Load half-line count |
| vload_val_i | input | 11 | Half-line count to load |
| sync_n_o | output | 1 | Composite sync |
| hd_n_o | output | 1 | Horizontal drive |
| fh_n_o | output | 1 | Line-rate square wave |
| f2h_n_o | output | 1 | Double-line-rate square wave |
| blk_n_o | output | 1 | Composite blanking |
| vd_n_o | output | 1 | Vertical drive |
| fld_n_o | output | 1 | Low in the second field |
| fld1_n_o | output | 1 | Low in the first field of the colour sequence |
| lalt_n_o | output | 1 | Line-alternate flag |
| bf_n_o | output | 1 | Burst flag |

## Verification
The assertions check the following on every cycle:
- the horizontal and half-line wraps and the priority of both loads;
- the inversion of the line-alternate register at each line end;
- that vertical drive always sits inside blanking;
- that the burst flag never coincides with vertical drive.

Only the bench scenarios can show:
- the exact pulse shapes of equalising, broad and horizontal sync in each standard;
- that the second field starts at the middle of a line;
- the four-field versus eight-field colour sequence across successive frame wraps.

// File: rtl/sync_pkg.sv
package sync_pkg;

  typedef enum logic [1:0] {
    STD_NTSC  = 2'b00,
    STD_SECAM = 2'b01,
    STD_PALM  = 2'b10,
    STD_PAL   = 2'b11
  } std_e;

  localparam int unsigned CLK_525   = 910;
  localparam int unsigned CLK_625   = 908;
  localparam int unsigned LINES_525 = 525;
  localparam int unsigned LINES_625 = 625;
  localparam int unsigned EQ_525    = 6;
  localparam int unsigned EQ_625    = 5;
  localparam int unsigned VD_525    = 18;
  localparam int unsigned VD_625    = 15;
  localparam int unsigned VB_525    = 40;
  localparam int unsigned VB_625    = 50;

  // bit 0 of the code selects the 625-line raster
  function automatic logic is_625(input logic [1:0] code);
    return code[0];
  endfunction

  // bit 1 of the code selects line alternation and the 8-field sequence
  function automatic logic is_alt(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/sync_hcount.sv
module sync_hcount
  import sync_pkg::*;
#(
  parameter int HCW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     std_i,
  input  logic           load_i,
  input  logic [HCW-1:0] load_val_i,
  output logic [HCW-1:0] hcnt_o,
  output logic           hend_o,
  output logic           hmid_o,
  output logic           lalt_o
);

  localparam logic [HCW-1:0] LAST_525 = HCW'(CLK_525 - 1);
  localparam logic [HCW-1:0] LAST_625 = HCW'(CLK_625 - 1);
  localparam logic [HCW-1:0] MID_525  = HCW'(CLK_525 / 2 - 1);
  localparam logic [HCW-1:0] MID_625  = HCW'(CLK_625 / 2 - 1);

  logic [HCW-1:0] hcnt_q, hcnt_d, last, mid;
  logic           lalt_q, lalt_d, hend, hmid;

  always_comb begin
    last = is_625(std_i) ? LAST_625 : LAST_525;
    mid  = is_625(std_i) ? MID_625  : MID_525;
    hend = (hcnt_q >= last);
    hmid = (hcnt_q == mid);
    if (load_i)      hcnt_d = load_val_i;
    else if (hend)   hcnt_d = '0;
    else             hcnt_d = hcnt_q + 1'b1;
    lalt_d = hend ? ~lalt_q : lalt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      lalt_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      lalt_q <= lalt_d;
    end
  end

  assign hcnt_o = hcnt_q;
  assign hend_o = hend;
  assign hmid_o = hmid;
  assign lalt_o = lalt_q;

  // R1: end of line returns the count to zero
  assert_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hend && !load_i) |=> (hcnt_q == '0));

  // R3: load wins over counting
  assert_h_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (hcnt_q == $past(load_val_i)));

  // R10: alternation register flips at every line end
  assert_lalt_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hend |=> (lalt_q != $past(lalt_q)));

endmodule

// File: rtl/sync_vcount.sv
module sync_vcount
  import sync_pkg::*;
#(
  parameter int VCW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     std_i,
  input  logic           tick_i,
  input  logic           load_i,
  input  logic [VCW-1:0] load_val_i,
  output logic [VCW-1:0] vcnt_o,
  output logic [1:0]     fcnt_o
);

  localparam logic [VCW-1:0] VMAX_525 = VCW'(2 * LINES_525 - 1);
  localparam logic [VCW-1:0] VMAX_625 = VCW'(2 * LINES_625 - 1);

  logic [VCW-1:0] vcnt_q, vcnt_d, vmax;
  logic [1:0]     fcnt_q, fcnt_d;
  logic           wrap;

  always_comb begin
    vmax = is_625(std_i) ? VMAX_625 : VMAX_525;
    wrap = tick_i && (vcnt_q >= vmax);
    if (load_i)      vcnt_d = load_val_i;
    else if (wrap)   vcnt_d = '0;
    else if (tick_i) vcnt_d = vcnt_q + 1'b1;
    else             vcnt_d = vcnt_q;
    fcnt_d = (wrap && !load_i) ? fcnt_q + 2'd1 : fcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      vcnt_q <= vcnt_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign vcnt_o = vcnt_q;
  assign fcnt_o = fcnt_q;

  // R2: last half line wraps to zero
  assert_v_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && vcnt_q >= vmax && !load_i) |=> (vcnt_q == '0));

  // R9: frame counter advances on the wrap
  assert_frame_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && vcnt_q >= vmax && !load_i) |=> (fcnt_q == $past(fcnt_q) + 2'd1));

  // R3: vertical load wins over counting
  assert_v_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vcnt_q == $past(load_val_i)));

endmodule

// File: rtl/sync_decode.sv
module sync_decode
  import sync_pkg::*;
#(
  parameter int HCW      = 10,
  parameter int VCW      = 11,
  parameter int HS_W     = 68,
  parameter int EQ_W     = 34,
  parameter int SERR_W   = 68,
  parameter int HD_W     = 96,
  parameter int HBLK_W   = 154,
  parameter int BF_START = 76,
  parameter int BF_W     = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     std_i,
  input  logic [HCW-1:0] hcnt_i,
  input  logic [VCW-1:0] vcnt_i,
  input  logic [1:0]     fcnt_i,
  input  logic           lalt_i,
  output logic           sync_n_o,
  output logic           hd_n_o,
  output logic           fh_n_o,
  output logic           f2h_n_o,
  output logic           blk_n_o,
  output logic           vd_n_o,
  output logic           fld_n_o,
  output logic           fld1_n_o,
  output logic           lalt_n_o,
  output logic           bf_n_o
);

  localparam logic [HCW-1:0] BF_END = HCW'(BF_START + BF_W);

  logic [HCW-1:0] half, hh;
  logic [VCW-1:0] lines, fpos, neq, neq2, neq3, vdl, vbl;
  logic           p625, second, vint, broad, vblank, first;

  always_comb begin
    p625   = is_625(std_i);
    half   = p625 ? HCW'(CLK_625 / 2) : HCW'(CLK_525 / 2);
    lines  = p625 ? VCW'(LINES_625) : VCW'(LINES_525);
    neq    = p625 ? VCW'(EQ_625) : VCW'(EQ_525);
    neq2   = p625 ? VCW'(2 * EQ_625) : VCW'(2 * EQ_525);
    neq3   = p625 ? VCW'(3 * EQ_625) : VCW'(3 * EQ_525);
    vdl    = p625 ? VCW'(VD_625) : VCW'(VD_525);
    vbl    = p625 ? VCW'(VB_625) : VCW'(VB_525);
    hh     = (hcnt_i >= half) ? hcnt_i - half : hcnt_i;
    second = (vcnt_i >= lines);
    fpos   = second ? vcnt_i - lines : vcnt_i;
    vint   = (fpos < neq3);
    broad  = (fpos >= neq) && (fpos < neq2);
    vblank = (fpos < vbl);
    first  = !second && (is_alt(std_i) ? (fcnt_i == 2'd0) : !fcnt_i[0]);

    if (vint)
      sync_n_o = broad ? !(hh < half - HCW'(SERR_W)) : !(hh < HCW'(EQ_W));
    else
      sync_n_o = !(hcnt_i < HCW'(HS_W));
    hd_n_o   = !(hcnt_i < HCW'(HD_W));
    fh_n_o   = !(hcnt_i < half);
    f2h_n_o  = !(hh < (half >> 1));
    blk_n_o  = !((hcnt_i < HCW'(HBLK_W)) || vblank);
    vd_n_o   = !(fpos < vdl);
    fld_n_o  = !second;
    fld1_n_o = !first;
    lalt_n_o = is_alt(std_i) ? lalt_i : 1'b1;
    bf_n_o   = !(!vblank && hcnt_i >= HCW'(BF_START) && hcnt_i < BF_END);
  end

  // R8: vertical drive lies inside vertical blanking
  assert_vd_in_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_n_o |-> !blk_n_o);

  // R11: burst flag never overlaps vertical drive
  assert_bf_outside_vd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bf_n_o |-> vd_n_o);

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
  import sync_pkg::*;
#(
  parameter int HCW      = 10,
  parameter int VCW      = 11,
  parameter int HS_W     = 68,
  parameter int EQ_W     = 34,
  parameter int SERR_W   = 68,
  parameter int HD_W     = 96,
  parameter int HBLK_W   = 154,
  parameter int BF_START = 76,
  parameter int BF_W     = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     std_i,
  input  logic           hload_i,
  input  logic [HCW-1:0] hload_val_i,
  input  logic           vload_i,
  input  logic [VCW-1:0] vload_val_i,
  output logic           sync_n_o,
  output logic           hd_n_o,
  output logic           fh_n_o,
  output logic           f2h_n_o,
  output logic           blk_n_o,
  output logic           vd_n_o,
  output logic           fld_n_o,
  output logic           fld1_n_o,
  output logic           lalt_n_o,
  output logic           bf_n_o
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic [1:0]     fcnt;
  logic           hend, hmid, lalt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sync_hcount #(.HCW(HCW)) u_hcount (
    .clk(clk), .rst_n(rst_int_n), .std_i(std_i),
    .load_i(hload_i), .load_val_i(hload_val_i),
    .hcnt_o(hcnt), .hend_o(hend), .hmid_o(hmid), .lalt_o(lalt)
  );

  sync_vcount #(.VCW(VCW)) u_vcount (
    .clk(clk), .rst_n(rst_int_n), .std_i(std_i),
    .tick_i(hend | hmid), .load_i(vload_i), .load_val_i(vload_val_i),
    .vcnt_o(vcnt), .fcnt_o(fcnt)
  );

  sync_decode #(
    .HCW(HCW), .VCW(VCW), .HS_W(HS_W), .EQ_W(EQ_W), .SERR_W(SERR_W),
    .HD_W(HD_W), .HBLK_W(HBLK_W), .BF_START(BF_START), .BF_W(BF_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_int_n), .std_i(std_i),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .fcnt_i(fcnt), .lalt_i(lalt),
    .sync_n_o(sync_n_o), .hd_n_o(hd_n_o), .fh_n_o(fh_n_o), .f2h_n_o(f2h_n_o),
    .blk_n_o(blk_n_o), .vd_n_o(vd_n_o), .fld_n_o(fld_n_o), .fld1_n_o(fld1_n_o),
    .lalt_n_o(lalt_n_o), .bf_n_o(bf_n_o)
  );

endmodule

// File: tb/sync_timing_gen_tb.sv
module sync_timing_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // {std, hcount, half-line count, expected {sync,hd,blk,vd,fld,fh,f2h,bf}}
  localparam logic [30:0] VEC [NVEC] = '{
    {2'b00, 10'd10,  11'd0,   8'b00001001},
    {2'b00, 10'd40,  11'd0,   8'b10001001},
    {2'b00, 10'd100, 11'd8,   8'b01001001},
    {2'b00, 10'd400, 11'd8,   8'b11001011},
    {2'b00, 10'd460, 11'd100, 8'b11111101},
    {2'b00, 10'd80,  11'd100, 8'b10011000},
    {2'b00, 10'd20,  11'd600, 8'b00010001},
    {2'b00, 10'd500, 11'd530, 8'b11000101},
    {2'b00, 10'd10,  11'd544, 8'b00010001},
    {2'b11, 10'd460, 11'd14,  8'b01001101},
    {2'b11, 10'd460, 11'd15,  8'b11011101},
    {2'b01, 10'd907, 11'd640, 8'b11010111},
    {2'b10, 10'd909, 11'd50,  8'b11111111},
    {2'b11, 10'd200, 11'd7,   8'b01001001},
    {2'b11, 10'd90,  11'd100, 8'b10011000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  std;
  logic        hload, vload;
  logic [9:0]  hval;
  logic [10:0] vval;
  logic sync_n, hd_n, fh_n, f2h_n, blk_n, vd_n, fld_n, fld1_n, lalt_n, bf_n;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .std_i(std),
    .hload_i(hload), .hload_val_i(hval), .vload_i(vload), .vload_val_i(vval),
    .sync_n_o(sync_n), .hd_n_o(hd_n), .fh_n_o(fh_n), .f2h_n_o(f2h_n),
    .blk_n_o(blk_n), .vd_n_o(vd_n), .fld_n_o(fld_n), .fld1_n_o(fld1_n),
    .lalt_n_o(lalt_n), .bf_n_o(bf_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [9:0] h, input logic [10:0] v);
    @(negedge clk);
    std = s; hload = 1'b1; hval = h; vload = 1'b1; vval = v;
    @(negedge clk);
    hload = 1'b0; vload = 1'b0;
    #1;
  endtask

  task automatic frame_wrap();
    load(std, std[0] ? 10'd907 : 10'd909, std[0] ? 11'd1249 : 11'd1049);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    std = 2'b00; hload = 1'b0; vload = 1'b0; hval = '0; vval = '0;
    do_reset();
    // R12 reset state
    chk("R12 sync", sync_n, 1'b0);
    chk("R12 hd", hd_n, 1'b0);
    chk("R12 blk", blk_n, 1'b0);
    chk("R12 vd", vd_n, 1'b0);
    chk("R12 fld", fld_n, 1'b1);
    chk("R12 fld1", fld1_n, 1'b0);
    chk("R12 lalt", lalt_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // decode vectors
    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][30:29], VEC[i][28:19], VEC[i][18:8]);
      chk("R5 R6 sync", sync_n, VEC[i][7]);
      chk("R4 hd", hd_n, VEC[i][6]);
      chk("R7 blk", blk_n, VEC[i][5]);
      chk("R8 vd", vd_n, VEC[i][4]);
      chk("R2 fld", fld_n, VEC[i][3]);
      chk("R4 fh", fh_n, VEC[i][2]);
      chk("R4 f2h", f2h_n, VEC[i][1]);
      chk("R11 bf", bf_n, VEC[i][0]);
    end

    // R1: 910-clock line keeps counting past 907, 908-clock line wraps there
    load(2'b00, 10'd907, 11'd100);
    @(negedge clk); #1;
    chk("R1 ntsc no wrap at 908", hd_n, 1'b1);
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk("R1 ntsc wrap after 910", hd_n, 1'b0);
    load(2'b11, 10'd907, 11'd100);
    @(negedge clk); #1;
    chk("R1 pal wrap after 908", hd_n, 1'b0);

    // R2: second field begins at mid-line
    load(2'b00, 10'd454, 11'd524);
    chk("R2 before mid-line fld", fld_n, 1'b1);
    chk("R8 before mid-line vd", vd_n, 1'b1);
    @(negedge clk); #1;
    chk("R2 field two at mid-line", fld_n, 1'b0);
    chk("R8 vd starts at mid-line", vd_n, 1'b0);
    chk("R6 equalising at mid-line", sync_n, 1'b0);

    // R3: held load keeps the count
    @(negedge clk);
    std = 2'b00; hload = 1'b1; hval = 10'd95;
    @(negedge clk);
    @(negedge clk);
    hload = 1'b0; #1;
    chk("R3 held load", hd_n, 1'b0);
    @(negedge clk); #1;
    chk("R3 counts after release", hd_n, 1'b1);

    // R10: line alternation
    begin
      logic a;
      std = 2'b00; #1;
      chk("R10 ntsc lalt high", lalt_n, 1'b1);
      @(negedge clk);
      std = 2'b11; hload = 1'b1; hval = 10'd907;
      @(negedge clk);
      hload = 1'b0; #1;
      a = lalt_n;
      @(negedge clk); #1;
      chk("R10 pal lalt inverts", lalt_n, ~a);
      @(negedge clk); #1;
      chk("R10 pal lalt steady mid-line", lalt_n, ~a);
    end

    // R9: colour-frame sequence
    std = 2'b00;
    do_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame_wrap();
    chk("R9 ntsc frame1", fld1_n, 1'b1);
    chk("R2 wrap to field one", fld_n, 1'b1);
    frame_wrap();
    chk("R9 ntsc frame2", fld1_n, 1'b0);
    @(negedge clk);
    std = 2'b11; #1;
    chk("R9 pal frame2", fld1_n, 1'b1);
    frame_wrap();
    chk("R9 pal frame3", fld1_n, 1'b1);
    frame_wrap();
    chk("R9 pal frame0", fld1_n, 1'b0);
    load(2'b11, 10'd300, 11'd700);
    chk("R9 second field not first", fld1_n, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule